// File: doc/BRIEF.md
# Two-Processor Bus Grant Arbiter with Idle Parking

This block decides which of two processors may drive a shared processor bus. Each processor raises a request line. The arbiter answers with a registered grant vector that is one-hot or all zero. A small control register selects one of two priority schemes. In the rotating scheme, a tie goes to the processor that did not hold the bus most recently. In the fixed scheme, processor 0 always wins a tie. The same register also chooses what happens to the grant while nobody requests the bus: it can be dropped, left with the last holder, or placed on a chosen processor.

A board strap decides whether this arbiter is in charge. The strap is captured while reset is active and is reported in a read-only status bit. When the captured value is 0, another arbiter owns the bus, and this block keeps both grants low. An owner keeps its grant for as long as it holds its request. A grant never moves directly from one processor to the other: at least one cycle with no grant always separates them.

Top module: `cpu_pair_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `cpu_gnt` is 00 and the control fields read back as 0. The last-holder record starts at processor 0.
- R2: `cfg_rdata` is {enable, park[1:0], rotate}. A write with `cfg_wr`=1 stores bits [2:0] of `cfg_wdata`. Bit 3 of the readback is the strap value captured in reset, and writing that bit has no effect.
- R3: When the captured enable is 0, `cpu_gnt` stays 00 in every cycle.
- R4: With rotate=0, both processors requesting on an idle bus gives `cpu_gnt`=01 (processor 0) one cycle later.
- R5: With rotate=1, both processors requesting on an idle bus grants the processor that is not the last holder.
- R6: A processor whose grant and request are both high keeps its grant on the next cycle, whatever the other request does.
- R7: When the holder drops its request while the other processor requests, the next cycle shows `cpu_gnt`=00, and the cycle after that grants the other processor.
- R8: With park=00 and no requests, `cpu_gnt` settles to 00.
- R9: With park=01 and no requests, the grant rests on the last holder. If that processor still holds the grant, it keeps it without a gap.
- R10: With no requests, park=10 places the grant on processor 0 and park=11 places it on processor 1. Moving an existing grant to the parking target first passes through 00.
- R11: A parked processor that raises its request keeps its grant with no gap. A request from the other processor clears the parked grant one cycle before granting the requester.
- R12: `cpu_gnt` is one-hot or zero in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_active | input | 1 | Strap sampled during reset: 1 means this block arbitrates |
| cpu_req | input | 2 | Bus requests; bit 0 from processor 0, bit 1 from processor 1 |
| cpu_gnt | output | 2 | Registered grants, same bit order as `cpu_req` |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 4 | Write data; [0] rotate, [2:1] park mode, [3] ignored |
| cfg_rdata | output | 4 | Readback {enable, park[1:0], rotate} |

## Verification
Release handover and idle parking can both apply in the same cycle. The case is a holder that drops its request while the parking policy points at the other processor, or while the other processor starts requesting. The stimulus table sets up exactly these cycles under park modes 01, 10 and 11. A correct result shows a 00 cycle before the new grant, or, when the parking target equals the current holder, a grant that continues unbroken. A configuration write also lands in the same cycle as an idle re-park. The expected value for that cycle follows the old park mode, because the new field only takes effect one edge later.

// File: rtl/cpu_arb_pkg.sv
package cpu_arb_pkg;

  localparam int unsigned NUM_CPU = 2;

  typedef enum logic [1:0] {
    PARK_NONE = 2'b00,
    PARK_LAST = 2'b01,
    PARK_CPU0 = 2'b10,
    PARK_CPU1 = 2'b11
  } park_mode_e;

  typedef struct packed {
    park_mode_e park;
    logic       rotate;
  } arb_cfg_t;

  localparam int unsigned CFG_W = $bits(arb_cfg_t);
  localparam int unsigned REG_W = CFG_W + 1;

  // Tie-break: fixed favours CPU0, rotating favours the non-last holder.
  function automatic logic [NUM_CPU-1:0] fn_winner(
    input logic [NUM_CPU-1:0] req,
    input logic               rotate,
    input logic               last_holder
  );
    logic [NUM_CPU-1:0] w;
    if (req == 2'b11) begin
      if (rotate) w = last_holder ? 2'b01 : 2'b10;
      else        w = 2'b01;
    end else begin
      w = req;
    end
    return w;
  endfunction

  function automatic logic [NUM_CPU-1:0] fn_park(
    input park_mode_e mode,
    input logic       last_holder
  );
    logic [NUM_CPU-1:0] p;
    case (mode)
      PARK_LAST: p = last_holder ? 2'b10 : 2'b01;
      PARK_CPU0: p = 2'b01;
      PARK_CPU1: p = 2'b10;
      default:   p = 2'b00;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/cpu_arb_regs.sv
module cpu_arb_regs
  import cpu_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_active,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output arb_cfg_t         cfg,
  output logic             arb_en
);

  arb_cfg_t cfg_q;
  logic     en_q;

  // Named event: software tried to touch the read-only enable bit.
  logic en_write_attempt;
  assign en_write_attempt = wr_en & wdata[REG_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      en_q  <= strap_active;
    end else if (wr_en) begin
      cfg_q <= arb_cfg_t'(wdata[CFG_W-1:0]);
    end
  end

  assign cfg    = cfg_q;
  assign arb_en = en_q;
  assign rdata  = {en_q, cfg_q};

  assert_en_wr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_write_attempt |=> en_q == $past(en_q));

  assert_en_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(en_q));

endmodule

// File: rtl/cpu_arb_core.sv
module cpu_arb_core
  import cpu_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arb_en,
  input  arb_cfg_t           cfg,
  input  logic [NUM_CPU-1:0] req,
  output logic [NUM_CPU-1:0] gnt
);

  logic [NUM_CPU-1:0] gnt_q;
  logic               last_q;

  // Named internal events for the assertions.
  logic               bus_owned;
  logic               last_eff;
  logic               hold_hit;
  logic [NUM_CPU-1:0] pick;
  logic [NUM_CPU-1:0] park_tgt;
  logic [NUM_CPU-1:0] tgt;
  logic               handover_gap;
  logic [NUM_CPU-1:0] gnt_d;

  assign bus_owned    = |gnt_q;
  assign last_eff     = bus_owned ? gnt_q[1] : last_q;
  assign hold_hit     = |(gnt_q & req);
  assign pick         = fn_winner(req, cfg.rotate, last_eff);
  assign park_tgt     = fn_park(cfg.park, last_eff);
  assign tgt          = hold_hit ? gnt_q : ((|req) ? pick : park_tgt);
  assign handover_gap = bus_owned && (tgt != gnt_q);
  assign gnt_d        = (!arb_en || handover_gap) ? '0 : tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      last_q <= 1'b0;
    end else begin
      gnt_q <= gnt_d;
      if (bus_owned) last_q <= gnt_q[1];
    end
  end

  assign gnt = gnt_q;

  assert_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en |-> gnt_q == '0);

  assert_tenure_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && hold_hit) |=> gnt_q == $past(gnt_q));

  assert_break_before_make_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q != '0 && $past(gnt_q) != '0) |-> gnt_q == $past(gnt_q));

  assert_no_park_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.park == PARK_NONE && req == '0 && gnt_q == '0) |=> gnt_q == '0);

endmodule

// File: rtl/cpu_pair_arbiter.sv
module cpu_pair_arbiter
  import cpu_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_active,
  input  logic [1:0]       cpu_req,
  output logic [1:0]       cpu_gnt,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata
);

  arb_cfg_t cfg;
  logic     arb_en;

  cpu_arb_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_active (strap_active),
    .wr_en        (cfg_wr),
    .wdata        (cfg_wdata),
    .rdata        (cfg_rdata),
    .cfg          (cfg),
    .arb_en       (arb_en)
  );

  cpu_arb_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .arb_en (arb_en),
    .cfg    (cfg),
    .req    (cpu_req),
    .gnt    (cpu_gnt)
  );

endmodule

// File: tb/cpu_pair_arbiter_tb.sv
`timescale 1ns/1ps
module cpu_pair_arbiter_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] req = 2'b00;
  logic       wr = 1'b0;
  logic [3:0] wdata = 4'h0;
  logic [1:0] gnt, gnt_off;
  logic [3:0] rdata, rdata_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cpu_pair_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .strap_active(1'b1),
    .cpu_req(req), .cpu_gnt(gnt),
    .cfg_wr(wr), .cfg_wdata(wdata), .cfg_rdata(rdata)
  );

  cpu_pair_arbiter u_dut_off (
    .clk(clk), .rst_n(rst_n), .strap_active(1'b0),
    .cpu_req(req), .cpu_gnt(gnt_off),
    .cfg_wr(wr), .cfg_wdata(wdata), .cfg_rdata(rdata_off)
  );

  // Vector layout: [8] write, [7:4] write data, [3:2] requests, [1:0] expected grant.
  localparam int NVEC = 29;
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 4'h0, 2'b00, 2'b00},  // 0  R8 no parking
    {1'b0, 4'h0, 2'b11, 2'b01},  // 1  R4 fixed tie -> CPU0
    {1'b0, 4'h0, 2'b11, 2'b01},  // 2  R6 hold
    {1'b0, 4'h0, 2'b10, 2'b00},  // 3  R7 gap
    {1'b0, 4'h0, 2'b10, 2'b10},  // 4  R7 new owner
    {1'b0, 4'h0, 2'b10, 2'b10},  // 5  R6
    {1'b0, 4'h0, 2'b00, 2'b00},  // 6  R8
    {1'b1, 4'h3, 2'b00, 2'b00},  // 7  R8 old mode still applies
    {1'b0, 4'h0, 2'b00, 2'b10},  // 8  R9 park on last (CPU1)
    {1'b0, 4'h0, 2'b10, 2'b10},  // 9  R11 parked requester, no gap
    {1'b0, 4'h0, 2'b11, 2'b10},  // 10 R6
    {1'b0, 4'h0, 2'b01, 2'b00},  // 11 R7
    {1'b0, 4'h0, 2'b01, 2'b01},  // 12 R7
    {1'b0, 4'h0, 2'b11, 2'b01},  // 13 R6
    {1'b0, 4'h0, 2'b10, 2'b00},  // 14 R7
    {1'b0, 4'h0, 2'b11, 2'b10},  // 15 R5 rotate, last=CPU0
    {1'b0, 4'h0, 2'b00, 2'b10},  // 16 R9 stays on holder
    {1'b0, 4'h0, 2'b01, 2'b00},  // 17 R7
    {1'b0, 4'h0, 2'b11, 2'b01},  // 18 R5 rotate, last=CPU1
    {1'b0, 4'h0, 2'b00, 2'b01},  // 19 R9
    {1'b1, 4'h5, 2'b00, 2'b01},  // 20 R9 old mode
    {1'b0, 4'h0, 2'b00, 2'b01},  // 21 R10 park CPU0
    {1'b1, 4'h7, 2'b00, 2'b01},  // 22 R10 old mode
    {1'b0, 4'h0, 2'b00, 2'b00},  // 23 R10 move via 00
    {1'b0, 4'h0, 2'b00, 2'b10},  // 24 R10 park CPU1
    {1'b0, 4'h0, 2'b01, 2'b00},  // 25 R11 park cleared first
    {1'b0, 4'h0, 2'b01, 2'b01},  // 26 R11 requester granted
    {1'b1, 4'h8, 2'b00, 2'b00},  // 27 R10 old mode -> to CPU1 via 00
    {1'b0, 4'h0, 2'b00, 2'b00}   // 28 R8
  };

  function automatic string vec_tag(int i);
    case (i)
      1:                  return "R4";
      15, 18:             return "R5";
      2, 5, 10, 13:       return "R6";
      3, 4, 11, 12, 14, 17: return "R7";
      8, 16, 19, 20:      return "R9";
      21, 22, 23, 24, 27: return "R10";
      9, 25, 26:          return "R11";
      default:            return "R8";
    endcase
  endfunction

  task automatic check2(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check4(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset values, enable captured from strap
    #12;
    check2("R1 gnt in reset", gnt, 2'b00);
    check4("R1 readback in reset", rdata, 4'b1000);
    check4("R3 readback off", rdata_off, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check2("R1 gnt after reset", gnt, 2'b00);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      wr    = VEC[i][8];
      wdata = VEC[i][7:4];
      req   = VEC[i][3:2];
      @(posedge clk); #1;
      check2(vec_tag(i), gnt, VEC[i][1:0]);
      check2("R3 disabled grant", gnt_off, 2'b00);
      check2("R12 one-hot", ($countones(gnt) <= 1) ? 2'b00 : gnt, 2'b00);
    end

    // R2: enable bit write was ignored (vector 27 wrote 1000)
    @(negedge clk);
    wr = 1'b0; req = 2'b00;
    #1;
    check4("R2 enable write ignored", rdata, 4'b1000);
    wr = 1'b1; wdata = 4'h6;
    @(negedge clk);
    wr = 1'b0;
    check4("R2 readback", rdata, 4'b1110);
    check4("R2 readback off", rdata_off, 4'b0110);
    check2("R3 disabled after write", gnt_off, 2'b00);

    // R1: reset while a grant is parked (park=11 -> CPU1)
    @(negedge clk);
    check2("R10 parked CPU1", gnt, 2'b10);
    rst_n = 1'b0;
    #1;
    check2("R1 async clear", gnt, 2'b00);
    check4("R1 fields cleared", rdata, 4'b1000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check2("R1 idle after reset", gnt, 2'b00);
    finish_run();
  end

endmodule